// File: doc/BRIEF.md
# Registered Two-Way Byte Transceiver

This block moves a byte between two ports, A and B, in either direction. Each direction has its own holding register, and each register is loaded by its own clock. A per-direction select picks what the driven side receives. It can be the live byte from the opposite port, passed straight through with no register stage, or the byte last captured from that port.

Each two-way pin group appears as three signals: an input, an output and an output enable. Tri-state resolution is left to the pad ring. An active-low global enable and a direction input decide which side, if either, drives. Captures never depend on those two inputs, so a register keeps sampling its port while the outputs are off. An active-low asynchronous reset clears both registers.

Top module: `dpx_xcvr`

## Requirements
- R1: While `oe_n` is 1, `a_oe` and `b_oe` are both 0.
- R2: While `oe_n` is 0, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0. The two enables are never 1 together.
- R3: Every rising edge of `clk_ab` loads `a_in` into the A-side register, whatever the values of `oe_n` and `dir`.
- R4: Every rising edge of `clk_ba` loads `b_in` into the B-side register, whatever the values of `oe_n` and `dir`.
- R5: While `b_oe`=1 and `sel_ab`=0, `b_out` equals the current `a_in`, combinationally.
- R6: While `b_oe`=1 and `sel_ab`=1, `b_out` equals the A-side register.
- R7: While `a_oe`=1, `a_out` equals the current `b_in` when `sel_ba`=0 and equals the B-side register when `sel_ba`=1.
- R8: In stored mode, the byte captured by a rising edge appears on the driven output directly after that same edge, with no additional edge.
- R9: A register is written only by its own clock. An edge of the other clock leaves it unchanged.
- R10: `rst_n`=0 clears both registers to 0 at once, without waiting for a clock.
- R11: An output whose enable is 0 is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| oe_n | input | 1 | Global output enable, active low |
| dir | input | 1 | 1: drive B, 0: drive A |
| sel_ab | input | 1 | B output source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A output source: 0 live B, 1 stored B |
| a_in | input | 8 | Byte received on port A |
| a_out | output | 8 | Byte driven onto port A |
| a_oe | output | 1 | Drive enable of port A |
| b_in | input | 8 | Byte received on port B |
| b_out | output | 8 | Byte driven onto port B |
| b_oe | output | 1 | Drive enable of port B |

## Verification
The enables, the transparent outputs and the zeroing of a disabled side are combinational, so they are due once the inputs settle, in the same time step. A stored output changes only at the rising edge of its own capture clock and is due directly after that edge, never one edge later. Reset takes effect while `rst_n` is still low. The bench changes inputs while both clocks are low and gives each vector at most one rising edge. It samples all four outputs after the falling edge, so every result, combinational or registered, has settled and none is read at an edge.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    // Drive enables produced by the enable decoder
    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } dpx_oe_t;

    // Output path source
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } dpx_src_e;

endpackage

// File: rtl/dpx_capture_reg.sv
module dpx_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    // A capture happens on every edge of this clock; no enable gates it
    always_comb begin
        cap_d      = cap_q;
        cap_d.data = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign q = cap_q.data;

    AST_CAPTURE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q == $past(d)));                                   // R3, R4

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (q == '0));                                        // R10
endmodule

// File: rtl/dpx_oe_decode.sv
module dpx_oe_decode
    import dpx_pkg::*;
(
    input  logic    oe_n,
    input  logic    dir,
    output dpx_oe_t oe
);
    always_comb begin
        oe         = '0;
        oe.drive_b = !oe_n &&  dir;
        oe.drive_a = !oe_n && !dir;
    end
endmodule

// File: rtl/dpx_path_sel.sv
module dpx_path_sel
    import dpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         en,
    input  dpx_src_e     src,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);
    typedef struct packed {
        logic [W-1:0] pick;
        logic [W-1:0] out;
    } sel_t;

    sel_t sel_d;

    // Source pick first, then a gate that holds a disabled side at zero
    always_comb begin
        sel_d      = '0;
        sel_d.pick = (src == SRC_STORED) ? stored : live;
        sel_d.out  = en ? sel_d.pick : '0;
    end

    assign y = sel_d.out;
endmodule

// File: rtl/dpx_xcvr.sv
module dpx_xcvr
    import dpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    dpx_oe_t      oe;
    logic [W-1:0] a_held;
    logic [W-1:0] b_held;

    dpx_oe_decode u_oe (
        .oe_n (oe_n),
        .dir  (dir),
        .oe   (oe)
    );

    // Each register lives in the domain of its own capture clock
    dpx_capture_reg #(.W(W)) u_reg_a (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d     (a_in),
        .q     (a_held)
    );

    dpx_capture_reg #(.W(W)) u_reg_b (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d     (b_in),
        .q     (b_held)
    );

    dpx_path_sel #(.W(W)) u_to_b (
        .en     (oe.drive_b),
        .src    (dpx_src_e'(sel_ab)),
        .live   (a_in),
        .stored (a_held),
        .y      (b_out)
    );

    dpx_path_sel #(.W(W)) u_to_a (
        .en     (oe.drive_a),
        .src    (dpx_src_e'(sel_ba)),
        .live   (b_in),
        .stored (b_held),
        .y      (a_out)
    );

    assign a_oe = oe.drive_a;
    assign b_oe = oe.drive_b;

    AST_ISOLATED_WHEN_OFF: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe));                                   // R1

    AST_ONE_SIDE_DRIVES: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !(a_oe && b_oe));                                             // R2

    AST_B_LIVE_PATH: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (b_oe && !sel_ab) |-> (b_out == a_in));                       // R5

    AST_B_HELD_PATH: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (b_oe && sel_ab) |-> (b_out == a_held));                      // R6

    AST_A_HELD_PATH: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (a_oe && sel_ba) |-> (a_out == b_held));                      // R7

    AST_B_QUIET_OFF: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !b_oe |-> (b_out == '0));                                     // R11

    AST_A_QUIET_OFF: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !a_oe |-> (a_out == '0));                                     // R11
endmodule

// File: tb/tb_dpx_xcvr.sv
module tb_dpx_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 12;

    typedef struct packed {
        logic       oe_n;
        logic       dir;
        logic       sab;
        logic       sba;
        logic       pab;
        logic       pba;
        logic [7:0] a;
        logic [7:0] b;
        logic       ea_oe;
        logic       eb_oe;
        logic [7:0] ea;
        logic [7:0] eb;
        logic [3:0] ta;
        logic [3:0] tb;
    } vec_t;

    // Register contents carry from one row to the next
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h11,8'h22,1'b0,1'b0,8'h00,8'h00,4'd1,4'd1},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'h3C,8'h22,1'b0,1'b0,8'h00,8'h00,4'd1,4'd1},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h55,8'h22,1'b0,1'b1,8'h00,8'h3C,4'd11,4'd3},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hA5,8'h22,1'b0,1'b1,8'h00,8'hA5,4'd11,4'd5},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'hC3,8'h22,1'b0,1'b1,8'h00,8'hC3,4'd11,4'd8},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h0F,8'h22,1'b0,1'b1,8'h00,8'hC3,4'd11,4'd6},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h0F,8'h77,1'b0,1'b0,8'h00,8'h00,4'd1,4'd1},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h0F,8'h99,1'b1,1'b0,8'h77,8'h00,4'd4,4'd11},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h0F,8'hE1,1'b1,1'b0,8'hE1,8'h00,4'd7,4'd11},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h0F,8'h2B,1'b1,1'b0,8'h2B,8'h00,4'd8,4'd11},
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h44,8'h5D,1'b1,1'b0,8'h2B,8'h00,4'd9,4'd11},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h5D,1'b0,1'b1,8'h00,8'h44,4'd11,4'd6}
    };

    logic       rst_n, clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
    logic [7:0] a_in, a_out, b_in, b_out;
    logic       a_oe, b_oe;
    int         n_checks, n_fail;
    bit         done;

    dpx_xcvr dut (
        .rst_n  (rst_n),
        .clk_ab (clk_ab),
        .clk_ba (clk_ba),
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .a_in   (a_in),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_in   (b_in),
        .b_out  (b_out),
        .b_oe   (b_oe)
    );

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // One rising edge followed by its falling edge; the bench samples later
    task automatic pulse(input bit on_ab, input bit on_ba);
        #(CLK_PERIOD/2);
        if (on_ab) clk_ab = 1'b1;
        if (on_ba) clk_ba = 1'b1;
        #(CLK_PERIOD/2);
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        n_checks = 0; n_fail = 0; done = 1'b0;
        clk_ab = 1'b0; clk_ba = 1'b0; rst_n = 1'b0;
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'hFF; b_in = 8'hFF;
        #3;
        // Reset state: stored path to B shows the cleared register
        check("R10", "b_out in reset", b_out, 8'h00);
        check("R2",  "b_oe in reset",  {7'd0, b_oe}, 8'h01);
        dir = 1'b0;
        #1;
        check("R10", "a_out in reset", a_out, 8'h00);
        #(CLK_PERIOD);
        rst_n = 1'b1;
        #(CLK_PERIOD);

        for (int i = 0; i < NV; i++) begin
            oe_n = VECS[i].oe_n; dir = VECS[i].dir;
            sel_ab = VECS[i].sab; sel_ba = VECS[i].sba;
            a_in = VECS[i].a; b_in = VECS[i].b;
            pulse(VECS[i].pab, VECS[i].pba);
            check(VECS[i].oe_n ? "R1" : "R2", "a_oe", {7'd0, a_oe}, {7'd0, VECS[i].ea_oe});
            check(VECS[i].oe_n ? "R1" : "R2", "b_oe", {7'd0, b_oe}, {7'd0, VECS[i].eb_oe});
            check(tag_name(VECS[i].ta), "a_out", a_out, VECS[i].ea);
            check(tag_name(VECS[i].tb), "b_out", b_out, VECS[i].eb);
        end

        // R5: the live path follows a_in with no edge at all
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h6E;
        #1;
        check("R5", "b_out live", b_out, 8'h6E);
        a_in = 8'h91;
        #1;
        check("R5", "b_out live change", b_out, 8'h91);

        // R9: a clk_ba edge leaves the A-side register alone
        sel_ab = 1'b1; a_in = 8'h00; b_in = 8'h13;
        pulse(1'b0, 1'b1);
        check("R9", "A reg after clk_ba", b_out, 8'h44);

        // R10: asynchronous clear with no clock edge
        rst_n = 1'b0;
        #1;
        check("R10", "b_out after clear", b_out, 8'h00);
        dir = 1'b0; sel_ba = 1'b1;
        #1;
        check("R10", "a_out after clear", a_out, 8'h00);
        #(CLK_PERIOD);
        rst_n = 1'b1;
        #(CLK_PERIOD);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule